// File: doc/BRIEF.md
# Oscillator High-Phase Width Accumulator

This block converts the high-phase duration of a slow, asynchronous square wave into a digital code. It is meant for a process-monitor test structure that holds several oscillators on the die. A start pulse sets up a measurement: the block enables one oscillator, picked by a select input, and steers that oscillator's output into the measurement path. The wave is synchronized into the reference-clock domain. The block then counts reference ticks whenever the wave is high and adds them to a width code. In parallel it counts how many high phases have completed.

When the number of completed high phases equals a stop value latched at start, both counters freeze and a done flag rises. The oscillator enable falls at the same time. The code and the flag then hold until the next start pulse. The width counter saturates instead of wrapping and records the event in a sticky overflow flag. The oscillators themselves are analog and live outside this block. The bench stands in for them with behavioural models.

Top module: `pw_tdc`

## Requirements
- R1: Exactly one bit of the oscillator-enable bus, bit number equal to the latched select, is high while a measurement runs (run output high). All enable bits are low when no measurement runs.
- R2: The selected oscillator's synchronized wave drives the width counter, which adds one per reference cycle while that wave is high. With an ideal wave of H-cycle high phases and a stop value N, the final code is N*H.
- R3: The width code saturates at all-ones. An increment attempted at all-ones sets the overflow flag, and the flag stays set until the next start.
- R4: The cycle counter adds one at each synchronized falling edge that closes a counted high phase. When it becomes equal to the stop value, done rises, run falls, and the cycle output equals the stop value.
- R5: A high phase already in progress when the measurement begins is not counted. Counting starts only at the first synchronized rising edge after start.
- R6: A start pulse clears the code, the cycle count, done and overflow, and latches select and stop value. For a nonzero stop value, run is high in the cycle after the start edge.
- R7: A stop value of zero gives done high, run low and code zero in the cycle after the start edge.
- R8: After done, the code, the cycle count and done hold their values until the next start pulse.
- R9: Changes on the select and stop-value inputs while a measurement runs have no effect on that measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a measurement |
| sel_i | input | SEL_W | Oscillator select, latched at start |
| stop_i | input | CYC_W | Number of high phases to accumulate, latched at start |
| osc_bank_i | input | N_OSC | Raw outputs of the oscillator units |
| osc_en_o | output | N_OSC | One-hot oscillator enable |
| run_o | output | 1 | High while a measurement is in progress |
| done_o | output | 1 | End-of-count flag |
| ovf_o | output | 1 | Width code saturated |
| code_o | output | CODE_W | Accumulated high-phase width |
| cycles_o | output | CYC_W | Completed high phases |

## Verification
The run, enable, cleared counters and, for a zero stop value, the done flag are registered at the start edge. The bench therefore samples them at the falling clock edge right after the start pulse. A wave edge reaches the counters three reference edges after it occurs: two synchronizer stages, then the edge-detect register. Done therefore comes a data-dependent number of cycles after start. The bench polls done at falling edges with a bounded wait, checks the final code, cycle count and overflow there, and then re-samples after 15 idle cycles to confirm the values hold.

// File: rtl/pw_tdc_pkg.sv
package pw_tdc_pkg;
    // Edge seen on the synchronized oscillator wave in one reference cycle
    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } edge_e;
endpackage

// File: rtl/pw_osc_route.sv
module pw_osc_route #(
    parameter int N_OSC = 4,
    parameter int SEL_W = 2
) (
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [N_OSC-1:0] bank_i,
    output logic [N_OSC-1:0] en_o,
    output logic             wave_o
);
    logic [N_OSC-1:0] sel_oh;

    // One-hot decode of the select: drives both the enable and the mux
    for (genvar k = 0; k < N_OSC; k++) begin : g_dec
        assign sel_oh[k] = (sel_i == SEL_W'(k));
        assign en_o[k]   = en_i & sel_oh[k];
    end

    assign wave_o = |(bank_i & sel_oh);
endmodule

// File: rtl/pw_sync_edge.sv
module pw_sync_edge
    import pw_tdc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  preset_i,
    input  logic  din_i,
    output logic  lvl_o,
    output edge_e edge_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (preset_i) begin
            // Pretend the wave was high so a high phase in progress is not seen as a rise
            st_d = '{s1: 1'b1, s2: 1'b1, s3: 1'b1};
        end else begin
            st_d.s1 = din_i;
            st_d.s2 = st_q.s1;
            st_d.s3 = st_q.s2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o  = st_q.s2;
    assign edge_o = (st_q.s2 && !st_q.s3) ? EDGE_RISE :
                    (!st_q.s2 && st_q.s3) ? EDGE_FALL : EDGE_NONE;
endmodule

// File: rtl/pw_tdc_core.sv
module pw_tdc_core
    import pw_tdc_pkg::*;
#(
    parameter int SEL_W  = 2,
    parameter int CYC_W  = 4,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [CYC_W-1:0]  stop_i,
    input  logic              lvl_i,
    input  edge_e             edge_i,
    output logic              run_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              done_o,
    output logic              ovf_o,
    output logic [CYC_W-1:0]  cyc_o,
    output logic [CODE_W-1:0] code_o
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    typedef struct packed {
        logic              run;
        logic              done;
        logic              ovf;
        logic              armed;
        logic [SEL_W-1:0]  sel;
        logic [CYC_W-1:0]  stop;
        logic [CYC_W-1:0]  cyc;
        logic [CODE_W-1:0] code;
    } core_t;

    core_t st_d, st_q;
    logic [CYC_W-1:0] cyc_inc;

    always_comb begin
        st_d    = st_q;
        cyc_inc = st_q.cyc + 1'b1;
        if (start_i) begin
            st_d.run   = (stop_i != '0);
            st_d.done  = (stop_i == '0);
            st_d.ovf   = 1'b0;
            st_d.armed = 1'b0;
            st_d.sel   = sel_i;
            st_d.stop  = stop_i;
            st_d.cyc   = '0;
            st_d.code  = '0;
        end else if (st_q.run) begin
            if (edge_i == EDGE_RISE) st_d.armed = 1'b1;
            // Width accumulation, only inside a high phase that began after start
            if (lvl_i && (st_q.armed || edge_i == EDGE_RISE)) begin
                if (st_q.code == CODE_MAX) st_d.ovf  = 1'b1;
                else                       st_d.code = st_q.code + 1'b1;
            end
            // Cycle counter and decider: a counted high phase has closed
            if (edge_i == EDGE_FALL && st_q.armed) begin
                st_d.cyc = cyc_inc;
                if (cyc_inc == st_q.stop) begin
                    st_d.run  = 1'b0;
                    st_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o  = st_q.run;
    assign sel_o  = st_q.sel;
    assign done_o = st_q.done;
    assign ovf_o  = st_q.ovf;
    assign cyc_o  = st_q.cyc;
    assign code_o = st_q.code;
endmodule

// File: rtl/pw_tdc.sv
module pw_tdc
    import pw_tdc_pkg::*;
#(
    parameter int  N_OSC  = 4,
    parameter int  CYC_W  = 4,
    parameter int  CODE_W = 16,
    localparam int SEL_W  = (N_OSC > 1) ? $clog2(N_OSC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [CYC_W-1:0]  stop_i,
    input  logic [N_OSC-1:0]  osc_bank_i,
    output logic [N_OSC-1:0]  osc_en_o,
    output logic              run_o,
    output logic              done_o,
    output logic              ovf_o,
    output logic [CODE_W-1:0] code_o,
    output logic [CYC_W-1:0]  cycles_o
);
    logic             wave;
    logic             lvl;
    edge_e            edge_k;
    logic [SEL_W-1:0] sel_q;

    pw_osc_route #(.N_OSC(N_OSC), .SEL_W(SEL_W)) u_route (
        .en_i   (run_o),
        .sel_i  (sel_q),
        .bank_i (osc_bank_i),
        .en_o   (osc_en_o),
        .wave_o (wave)
    );

    pw_sync_edge u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .preset_i (start_i),
        .din_i    (wave),
        .lvl_o    (lvl),
        .edge_o   (edge_k)
    );

    pw_tdc_core #(.SEL_W(SEL_W), .CYC_W(CYC_W), .CODE_W(CODE_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .sel_i   (sel_i),
        .stop_i  (stop_i),
        .lvl_i   (lvl),
        .edge_i  (edge_k),
        .run_o   (run_o),
        .sel_o   (sel_q),
        .done_o  (done_o),
        .ovf_o   (ovf_o),
        .cyc_o   (cycles_o),
        .code_o  (code_o)
    );
endmodule

// File: rtl/pw_tdc_chk.sv
module pw_tdc_chk #(
    parameter int N_OSC  = 4,
    parameter int CYC_W  = 4,
    parameter int CODE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [CYC_W-1:0]  stop_i,
    input logic [N_OSC-1:0]  osc_en_o,
    input logic              run_o,
    input logic              done_o,
    input logic              ovf_o,
    input logic [CODE_W-1:0] code_o,
    input logic [CYC_W-1:0]  cycles_o
);
    p_en_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(osc_en_o));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_o |-> (osc_en_o == '0));

    p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && code_o == {CODE_W{1'b1}}) |=> (code_o == {CODE_W{1'b1}}));

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && ovf_o) |=> ovf_o);

    p_done_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !run_o);

    p_start_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && stop_i != '0) |=> (run_o && !done_o && !ovf_o && code_o == '0 && cycles_o == '0));

    p_zero_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && stop_i == '0) |=> (done_o && !run_o && code_o == '0));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> ($stable(code_o) && $stable(cycles_o) && done_o));
endmodule

bind pw_tdc pw_tdc_chk #(.N_OSC(N_OSC), .CYC_W(CYC_W), .CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .osc_en_o (osc_en_o),
    .run_o    (run_o),
    .done_o   (done_o),
    .ovf_o    (ovf_o),
    .code_o   (code_o),
    .cycles_o (cycles_o)
);

// File: tb/pw_tdc_tb.sv
module pw_tdc_tb;
    localparam int N_OSC  = 4;
    localparam int CYC_W  = 4;
    localparam int CODE_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [1:0]        sel_i = '0;
    logic [CYC_W-1:0]  stop_i = '0;
    logic [N_OSC-1:0]  bank = '0;
    logic [N_OSC-1:0]  osc_en;
    logic              run_o, done_o, ovf_o;
    logic [CODE_W-1:0] code_o;
    logic [CYC_W-1:0]  cycles_o;

    int n_chk  = 0;
    int n_fail = 0;
    int ph [N_OSC];

    always #10 clk = ~clk;

    pw_tdc #(.N_OSC(N_OSC), .CYC_W(CYC_W), .CODE_W(CODE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_i), .stop_i(stop_i),
        .osc_bank_i(bank), .osc_en_o(osc_en), .run_o(run_o), .done_o(done_o),
        .ovf_o(ovf_o), .code_o(code_o), .cycles_o(cycles_o)
    );

    // Oscillator models: high/low phase lengths in reference cycles
    function automatic int hi_len(input int k);
        case (k) 0: return 3; 1: return 7; 2: return 40; default: return 5; endcase
    endfunction
    function automatic int lo_len(input int k);
        case (k) 0: return 5; 1: return 2; 2: return 10; default: return 4; endcase
    endfunction

    // Unit 3 begins its run in the high phase (partial phase case); others begin low
    always @(negedge clk) begin
        for (int k = 0; k < N_OSC; k++) begin
            int p;
            if (!osc_en[k]) begin
                ph[k]   <= 0;
                bank[k] <= 1'b0;
            end else begin
                p = ph[k] % (hi_len(k) + lo_len(k));
                ph[k]   <= ph[k] + 1;
                bank[k] <= (k == 3) ? (p < hi_len(k)) : (p >= lo_len(k));
            end
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [1:0]       sel;
        logic [CYC_W-1:0] stop;
        logic [7:0]       code;
        logic             ovf;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 4'd4,  8'd12,  1'b0},
        '{2'd1, 4'd3,  8'd21,  1'b0},
        '{2'd1, 4'd15, 8'd105, 1'b0},
        '{2'd3, 4'd2,  8'd10,  1'b0},
        '{2'd2, 4'd6,  8'd240, 1'b0},
        '{2'd0, 4'd1,  8'd3,   1'b0},
        '{2'd2, 4'd7,  8'd255, 1'b1}
    };

    task automatic pulse_start(input logic [1:0] s, input logic [CYC_W-1:0] n);
        @(negedge clk);
        sel_i   = s;
        stop_i  = n;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R6: reset state
        chk("R6 reset code", int'(code_o), 0);
        chk("R6 reset done", int'(done_o), 0);
        chk("R1 reset enables idle", int'(osc_en), 0);
        chk("R1 reset run", int'(run_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            int t;
            pulse_start(VECS[v].sel, VECS[v].stop);
            chk("R6 run after start", int'(run_o), 1);
            chk("R6 cleared done", int'(done_o), 0);
            chk("R6 cleared code", int'(code_o), 0);
            chk("R1 one-hot enable", int'(osc_en), 1 << VECS[v].sel);
            // R9: disturb select and stop while running
            sel_i  = VECS[v].sel ^ 2'd1;
            stop_i = VECS[v].stop ^ 4'hF;
            t = 0;
            while (!done_o && t < 3000) begin
                @(negedge clk);
                t++;
            end
            chk("R4 done raised", int'(done_o), 1);
            chk("R2 code", int'(code_o), int'(VECS[v].code));
            chk("R4 cycles equal stop", int'(cycles_o), int'(VECS[v].stop));
            chk("R3 overflow flag", int'(ovf_o), int'(VECS[v].ovf));
            chk("R4 run low at done", int'(run_o), 0);
            chk("R1 enables idle at done", int'(osc_en), 0);
            if (VECS[v].sel == 2'd3)
                chk("R5 partial high excluded", int'(code_o), int'(VECS[v].code));
            if (VECS[v].sel == 2'd1 || VECS[v].sel == 2'd0)
                chk("R9 latched inputs", int'(cycles_o), int'(VECS[v].stop));
            repeat (15) @(negedge clk);
            chk("R8 code held", int'(code_o), int'(VECS[v].code));
            chk("R8 cycles held", int'(cycles_o), int'(VECS[v].stop));
            chk("R8 done held", int'(done_o), 1);
        end

        // R3: saturated value holds, then R7 zero stop right after an overflow run
        chk("R3 saturated code", int'(code_o), 255);
        pulse_start(2'd1, 4'd0);
        chk("R7 done one cycle after start", int'(done_o), 1);
        chk("R7 zero code", int'(code_o), 0);
        chk("R7 run stays low", int'(run_o), 0);
        chk("R6 overflow cleared by start", int'(ovf_o), 0);
        chk("R7 no enable", int'(osc_en), 0);
        repeat (10) @(negedge clk);
        chk("R8 zero result held", int'(code_o), 0);
        chk("R8 zero done held", int'(done_o), 1);

        finish_run();
    end
endmodule